// File: doc/BRIEF.md
# Cascaded Interrupt Aggregator with Bypass

This block is a second-level interrupt controller that sits beneath a parent controller. It accepts a vector of level-sensitive interrupt lines and drives several parent-facing request outputs. Each output gathers its own fixed subset of inputs, chosen by a per-output map mask, so the parent sees a few grouped requests instead of one combined line. Input positions that appear in no map and have no bypass path are treated as unwired and have no effect.

The lowest few inputs have a bypass mux. When a line's forward bit is set, that line drives its own dedicated parent output directly, with no clock in the path. It is then invisible to the controller: it does not appear in status, in any group or in the wake request. When its forward bit is clear, the dedicated output stays low and the line is handled like any other input. Software unmasks lines through an enable register and reads latched pending levels through a status register, over a small 8-byte register window. A wake request output tells power management that an enabled input is pending.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the enable register and status register both read zero, and every group output, bypass output and the wake request are low while the inputs are low.
- R2: Byte offset 0x0 is a 32-bit read/write enable register. A read (select high, write low) returns data on `bus_rdata` after the next rising clock edge.
- R3: Byte offset 0x4 is a read-only status register holding the input levels captured at the previous clock edge. Bits for unwired lines and forwarded lines read 0, and a write to 0x4 changes nothing.
- R4: An unwired position (set in no map mask and not a bypass line) never affects any output, whatever its level or enable bit.
- R5: Group output g is the OR over status AND enable AND map mask g. With the default masks, group 0 uses 0xEB8 (lines 3,4,5,7,9,10,11) and group 1 uses 0x140 (lines 6,8).
- R6: An input change reaches the group outputs exactly two rising edges later: one edge to capture status and one edge to register the output.
- R7: For a bypass line i (i < NUM_BYPASS) with `fwd_mask[i]` set, `byp_irq[i]` follows `irq_in[i]` combinationally, and the line is left out of status, all groups and the wake request.
- R8: For a bypass line with its forward bit clear, `byp_irq[i]` is low, and the line takes part in status and in any group whose map contains it.
- R9: `wake_req` is registered with the group outputs. It is high when `wake_en` is high and some line that is enabled, mapped to a group and not forwarded is pending in status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_LINES | Level-sensitive interrupt lines |
| fwd_mask | input | NUM_BYPASS | Static forward selection for bypass lines 0..NUM_BYPASS-1 |
| wake_en | input | 1 | Allows the wake request |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Byte offset in the window |
| bus_wdata | input | NUM_LINES | Write data |
| bus_rdata | output | NUM_LINES | Registered read data |
| agg_irq | output | NUM_GROUPS | Grouped requests to the parent |
| byp_irq | output | NUM_BYPASS | Dedicated bypass requests to the parent |
| wake_req | output | 1 | Wake request |

## Verification
The hardest case to reach is a bypass line that changes role: it is forwarded in one phase and aggregated in the next, while the same line is also mapped into a group. In that state, a leak from the status path or a stuck bypass output stays hidden unless the line is pending. The bench builds the block with bit 2 added to group 1's map. It then sweeps the forward selection and the input levels at random and compares group 1, the bypass line and the wake request against expected values for every pair. Directed phases drive all unwired lines high with every enable bit set, and check the two-edge latency on the edge before and the edge after the output changes.

// File: rtl/irq_cascade_pkg.sv
// Shared constants for the cascaded interrupt aggregator.
// Assumes an 8-byte register window addressed by byte offset.
package irq_cascade_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] ENABLE_OFS = 3'h0;
    localparam logic [ADDR_W-1:0] STATUS_OFS = 3'h4;
endpackage

// File: rtl/irq_cascade_regs.sv
// Register window: enable register (read/write) and status register
// (read-only capture of the inputs, qualified by keep_mask).
// Assumes one access per cycle; read data is registered.
module irq_cascade_regs
    import irq_cascade_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [NUM_LINES-1:0] keep_mask,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [NUM_LINES-1:0] bus_wdata,
    output logic [NUM_LINES-1:0] bus_rdata,
    output logic [NUM_LINES-1:0] enable_q,
    output logic [NUM_LINES-1:0] status_q
);
    logic [NUM_LINES-1:0] rdata_q;

    // Capture the qualified input levels every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= irq_in & keep_mask;
    end

    // Software writes to the enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable_q <= '0;
        else if (bus_sel && bus_wr && bus_addr == ENABLE_OFS)
            enable_q <= bus_wdata;
    end

    // Registered read data mux.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (bus_sel && !bus_wr) begin
            case (bus_addr)
                ENABLE_OFS: rdata_q <= enable_q;
                STATUS_OFS: rdata_q <= status_q;
                default:    rdata_q <= '0;
            endcase
        end
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/irq_cascade_agg.sv
// Grouping stage: one registered OR-tree per parent output, plus the wake
// request. Assumes status already excludes unwired and forwarded lines.
module irq_cascade_agg #(
    parameter int NUM_LINES  = 32,
    parameter int NUM_GROUPS = 2,
    parameter logic [NUM_GROUPS-1:0][NUM_LINES-1:0] MAP_MASKS = '0,
    parameter logic [NUM_LINES-1:0] MAPPED_ALL = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LINES-1:0]  status,
    input  logic [NUM_LINES-1:0]  enable,
    input  logic                  wake_en,
    output logic [NUM_GROUPS-1:0] agg_q,
    output logic                  wake_q
);
    logic [NUM_LINES-1:0] live;
    assign live = status & enable;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
        // Register the OR of the live lines that belong to this group.
        always_ff @(posedge clk) begin
            if (!rst_n) agg_q[g] <= 1'b0;
            else        agg_q[g] <= |(live & MAP_MASKS[g]);
        end
    end

    // Wake request when any grouped line is live.
    always_ff @(posedge clk) begin
        if (!rst_n) wake_q <= 1'b0;
        else        wake_q <= wake_en && |(live & MAPPED_ALL);
    end
endmodule

// File: rtl/irq_cascade_bypass.sv
// Bypass muxes: a forwarded line drives its dedicated output with no clock
// in the path, and a non-forwarded line leaves that output low.
module irq_cascade_bypass #(
    parameter int NUM_BYPASS = 3
) (
    input  logic [NUM_BYPASS-1:0] irq_low,
    input  logic [NUM_BYPASS-1:0] fwd_mask,
    output logic [NUM_BYPASS-1:0] byp_irq
);
    for (genvar i = 0; i < NUM_BYPASS; i++) begin : g_mux
        // Select either the raw line or a quiet level.
        always_comb byp_irq[i] = fwd_mask[i] ? irq_low[i] : 1'b0;
    end
endmodule

// File: rtl/irq_cascade_ctrl.sv
// Top of the cascaded interrupt aggregator. Lines 0..NUM_BYPASS-1 have
// bypass muxes. Each map mask selects the lines of one parent output.
// Assumes level-sensitive inputs that are synchronous to clk, and a
// fwd_mask that changes only while the affected lines are quiet.
module irq_cascade_ctrl
    import irq_cascade_pkg::*;
#(
    parameter int NUM_LINES  = 32,
    parameter int NUM_GROUPS = 2,
    parameter int NUM_BYPASS = 3,
    parameter logic [NUM_GROUPS-1:0][NUM_LINES-1:0] MAP_MASKS =
        {32'h0000_0140, 32'h0000_0EB8}
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LINES-1:0]  irq_in,
    input  logic [NUM_BYPASS-1:0] fwd_mask,
    input  logic                  wake_en,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [NUM_LINES-1:0]  bus_wdata,
    output logic [NUM_LINES-1:0]  bus_rdata,
    output logic [NUM_GROUPS-1:0] agg_irq,
    output logic [NUM_BYPASS-1:0] byp_irq,
    output logic                  wake_req
);
    function automatic logic [NUM_LINES-1:0] fold_maps();
        logic [NUM_LINES-1:0] acc = '0;
        for (int g = 0; g < NUM_GROUPS; g++) acc |= MAP_MASKS[g];
        return acc;
    endfunction

    localparam logic [NUM_LINES-1:0] MAPPED_ALL = fold_maps();
    localparam logic [NUM_LINES-1:0] BYP_BITS   =
        {{(NUM_LINES-NUM_BYPASS){1'b0}}, {NUM_BYPASS{1'b1}}};
    localparam logic [NUM_LINES-1:0] WIRED      = MAPPED_ALL | BYP_BITS;

    logic [NUM_LINES-1:0] fwd_wide;
    logic [NUM_LINES-1:0] keep_mask;
    logic [NUM_LINES-1:0] enable_q;
    logic [NUM_LINES-1:0] status_q;

    // Forwarded lines and unwired positions are kept out of the status path.
    always_comb begin
        fwd_wide  = {{(NUM_LINES-NUM_BYPASS){1'b0}}, fwd_mask};
        keep_mask = WIRED & ~fwd_wide;
    end

    irq_cascade_regs #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .keep_mask(keep_mask),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .enable_q(enable_q), .status_q(status_q)
    );

    irq_cascade_agg #(
        .NUM_LINES(NUM_LINES), .NUM_GROUPS(NUM_GROUPS),
        .MAP_MASKS(MAP_MASKS), .MAPPED_ALL(MAPPED_ALL)
    ) u_agg (
        .clk(clk), .rst_n(rst_n), .status(status_q), .enable(enable_q),
        .wake_en(wake_en), .agg_q(agg_irq), .wake_q(wake_req)
    );

    irq_cascade_bypass #(.NUM_BYPASS(NUM_BYPASS)) u_byp (
        .irq_low(irq_in[NUM_BYPASS-1:0]), .fwd_mask(fwd_mask),
        .byp_irq(byp_irq)
    );
endmodule

// File: rtl/irq_cascade_ctrl_chk.sv
// Checker bound to irq_cascade_ctrl. It relates outputs, bus reads and the
// captured status across clock edges.
module irq_cascade_ctrl_chk
    import irq_cascade_pkg::*;
#(
    parameter int NUM_LINES  = 32,
    parameter int NUM_GROUPS = 2,
    parameter int NUM_BYPASS = 3,
    parameter logic [NUM_LINES-1:0] WIRED = '0
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_BYPASS-1:0] fwd_mask,
    input logic                  wake_en,
    input logic                  bus_sel,
    input logic                  bus_wr,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [NUM_LINES-1:0]  bus_rdata,
    input logic [NUM_GROUPS-1:0] agg_irq,
    input logic [NUM_BYPASS-1:0] byp_irq,
    input logic                  wake_req,
    input logic [NUM_LINES-1:0]  status_q
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (agg_irq == '0 && !wake_req)); // R1

    AST_UNWIRED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_sel && !bus_wr && bus_addr == STATUS_OFS)
        |-> ((bus_rdata & ~WIRED) == '0)); // R4

    AST_FWD_SKIPS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(status_q[NUM_BYPASS-1:0] & $past(fwd_mask)) == 0); // R7

    AST_BYPASS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(byp_irq & ~fwd_mask) == 0); // R8

    AST_WAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(wake_en)); // R9
endmodule

bind irq_cascade_ctrl irq_cascade_ctrl_chk #(
    .NUM_LINES(NUM_LINES), .NUM_GROUPS(NUM_GROUPS),
    .NUM_BYPASS(NUM_BYPASS), .WIRED(WIRED)
) u_chk (
    .clk(clk), .rst_n(rst_n), .fwd_mask(fwd_mask), .wake_en(wake_en),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .agg_irq(agg_irq), .byp_irq(byp_irq),
    .wake_req(wake_req), .status_q(status_q)
);

// File: tb/irq_cascade_ctrl_test.sv
module irq_cascade_ctrl_test;
    localparam int NL = 32;
    localparam int NG = 2;
    localparam int NB = 3;
    localparam logic [31:0] MAP0 = 32'h0000_0EB8;
    localparam logic [31:0] MAP1 = 32'h0000_0144; // bit 2 added to group 1
    localparam logic [31:0] WIRED_M = MAP0 | MAP1 | 32'h7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NL-1:0] irq_in = '0;
    logic [NB-1:0] fwd_mask = '0;
    logic wake_en = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [NL-1:0] bus_wdata = '0;
    logic [NL-1:0] bus_rdata;
    logic [NG-1:0] agg_irq;
    logic [NB-1:0] byp_irq;
    logic wake_req;

    int checks = 0;
    int errors = 0;
    logic [31:0] en_model = '0;

    always #4 clk = ~clk;

    irq_cascade_ctrl #(
        .NUM_LINES(NL), .NUM_GROUPS(NG), .NUM_BYPASS(NB),
        .MAP_MASKS({MAP1, MAP0})
    ) uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .fwd_mask(fwd_mask),
        .wake_en(wake_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .agg_irq(agg_irq), .byp_irq(byp_irq), .wake_req(wake_req)
    );

    function automatic logic [31:0] exp_status(logic [31:0] in, logic [NB-1:0] f);
        return in & WIRED_M & ~{29'b0, f};
    endfunction
    function automatic logic [1:0] exp_agg(logic [31:0] st, logic [31:0] en);
        return {|(st & en & MAP1), |(st & en & MAP0)};
    endfunction
    function automatic logic exp_wake(logic [31:0] st, logic [31:0] en, logic we);
        return we && |(st & en & (MAP0 | MAP1));
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        if (a == 3'h0) en_model = d;
    endtask

    task automatic bus_read(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    // Compare every output and both registers against the model.
    task automatic full_check(string tag);
        logic [31:0] st, rd;
        st = exp_status(irq_in, fwd_mask);
        check({tag, " R5 agg"}, {30'b0, agg_irq}, {30'b0, exp_agg(st, en_model)});
        check({tag, " R9 wake"}, {31'b0, wake_req}, {31'b0, exp_wake(st, en_model, wake_en)});
        check({tag, " R7/R8 bypass"}, {29'b0, byp_irq}, {29'b0, fwd_mask & irq_in[2:0]});
        bus_read(3'h4, rd);
        check({tag, " R3 status"}, rd, st);
        bus_read(3'h0, rd);
        check({tag, " R2 enable"}, rd, en_model);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 agg", {30'b0, agg_irq}, 32'h0);
        check("R1 wake/byp", {28'b0, wake_req, byp_irq}, 32'h0);
        bus_read(3'h0, rd); check("R1 enable", rd, 32'h0);
        bus_read(3'h4, rd); check("R1 status", rd, 32'h0);

        // R2 enable read-back, R3 write to status ignored
        bus_write(3'h0, 32'hA5A5_0F0F);
        bus_read(3'h0, rd); check("R2 enable rw", rd, 32'hA5A5_0F0F);
        bus_write(3'h4, 32'hFFFF_FFFF);
        en_model = 32'hA5A5_0F0F;
        bus_read(3'h0, rd); check("R3 status write ignored (enable)", rd, 32'hA5A5_0F0F);
        bus_read(3'h4, rd); check("R3 status write ignored", rd, 32'h0);

        // R4 unwired lines all high with every line enabled
        bus_write(3'h0, 32'hFFFF_FFFF);
        wake_en = 1'b1;
        irq_in = 32'hFFFF_F000;
        settle();
        check("R4 agg quiet", {30'b0, agg_irq}, 32'h0);
        check("R4 wake quiet", {31'b0, wake_req}, 32'h0);
        bus_read(3'h4, rd); check("R4 status zero", rd, 32'h0);

        // R6 latency: line 6 (group 1) rises
        @(negedge clk);
        irq_in = 32'h0000_0040;
        @(negedge clk);
        check("R6 one edge", {30'b0, agg_irq}, 32'h0);
        @(negedge clk);
        check("R6 two edges", {30'b0, agg_irq}, 32'h2);
        check("R9 wake with agg", {31'b0, wake_req}, 32'h1);
        irq_in = '0;
        settle();

        // R7 forwarded bypass lines
        fwd_mask = 3'b111;
        irq_in = 32'h0000_0007;
        #1 check("R7 bypass comb", {29'b0, byp_irq}, 32'h7);
        settle();
        check("R7 agg excluded", {30'b0, agg_irq}, 32'h0);
        check("R7 wake excluded", {31'b0, wake_req}, 32'h0);
        bus_read(3'h4, rd); check("R7 status excluded", rd, 32'h0);

        // R8 same lines not forwarded
        fwd_mask = 3'b000;
        settle();
        check("R8 bypass low", {29'b0, byp_irq}, 32'h0);
        check("R8 group1 via line 2", {30'b0, agg_irq}, 32'h2);
        bus_read(3'h4, rd); check("R8 status", rd, 32'h7);
        irq_in = '0;

        // Random sweep
        for (int n = 0; n < 80; n++) begin
            @(negedge clk);
            irq_in   = $urandom;
            fwd_mask = 3'($urandom);
            wake_en  = 1'($urandom);
            bus_write(3'h0, (n % 4 == 0) ? 32'hFFFF_FFFF : $urandom);
            settle();
            full_check("rand");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule